// File: doc/BRIEF.md
# Carry-Save Array Unsigned Multiplier

This block multiplies two unsigned W-bit operands and returns the exact 2W-bit product. The product is not formed by a behavioural multiply. It comes from a regular array built from three parts:

- a grid of AND gates that forms every partial-product bit;
- W-1 rows of carry-save full adders that reduce those bits;
- a final ripple-carry row that merges the leftover sum and carry vectors.

The array uses W(W-1) full-adder cells in total, which is 12 cells at W=4. It is purely combinational, so its delay is the longest gate-and-adder path through it. There is no multi-cycle shift-and-add sequence.

The operands, a qualifier bit and a mode select are captured in an input register stage. The array result is captured in an output register stage. A new operand pair can be accepted on every clock. The mode select chooses how the product is presented:

- **Full mode** passes the whole 2W-bit product on unchanged, for a downstream stage that needs full accuracy.
- **High-half mode** drops the low W bits and returns only the upper W bits, right-aligned on the output.

Top module: `umul_array`

## Requirements
- R1: While `rst` is high, and on the first edge after it was high, `out_valid` is 0 and `product` is all zeros, whatever the other inputs are.
- R2: With `hi_only`=0 sampled alongside an operand pair, `product` equals the exact unsigned product `op_a*op_b` over all 2W bits.
- R3: With `hi_only`=1 sampled alongside an operand pair, `product[W-1:0]` equals bits [2W-1:W] of the exact product and `product[2W-1:W]` is zero.
- R4: An `in_valid` sampled high on a rising edge makes `out_valid` high after the second rising edge from then, with the matching result on `product`; `out_valid` is low in every other cycle.
- R5: Operand pairs presented with `in_valid` high on consecutive edges each yield their own result, in order, one per cycle, and the mode may differ from pair to pair.
- R6: While `in_valid` is low, operand and mode changes are ignored and `product` keeps the last result.
- R7: The extreme operands give exact results. A zero operand gives 0. All-ones times all-ones gives the pattern 1…10…01: W-1 ones, then a zero, then W-1 zeros, then a one. This requires the final carry to reach bit 2W-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies op_a, op_b and hi_only on this edge |
| op_a | input | W | Unsigned multiplicand |
| op_b | input | W | Unsigned multiplier |
| hi_only | input | 1 | 0: full 2W-bit product; 1: upper W bits only |
| out_valid | output | 1 | High for one cycle per accepted operand pair |
| product | output | 2W | Registered result in the selected format |

## Verification
Every result is due two rising edges after the edge that samples its `in_valid`. The first edge fills the input stage and the second fills the output stage. The bench drives inputs and samples outputs on falling edges, and keeps a two-slot queue of expected valid flags and products that advances once per falling edge. Each output is therefore compared with the stimulus applied two falling edges earlier. In cycles without a valid result, the comparison is against the last delivered value.

// File: rtl/umul_pkg.sv
package umul_pkg;

  // How the registered product is presented on the output port.
  typedef enum logic {
    OUT_FULL = 1'b0,  // all 2W bits
    OUT_HIGH = 1'b1   // upper W bits, right-aligned, upper half zero
  } out_mode_e;

endpackage

// File: rtl/umul_fa.sv
// Single-bit full adder: three inputs of equal weight, sum and carry out.
module umul_fa (
  input  logic x,
  input  logic y,
  input  logic z,
  output logic s,
  output logic co
);
  assign s  = x ^ y ^ z;
  assign co = (x & y) | (x & z) | (y & z);
endmodule

// File: rtl/umul_ppgen.sv
// Partial-product grid: row i holds op_b[i] AND every bit of op_a.
module umul_ppgen #(
  parameter int W = 8
) (
  input  logic [W-1:0]         a,
  input  logic [W-1:0]         b,
  output logic [W-1:0][W-1:0]  pp
);
  for (genvar i = 0; i < W; i++) begin : g_pp_row
    assign pp[i] = a & {W{b[i]}};
  end
endmodule

// File: rtl/umul_ripple.sv
// Final merge row: ripple-carry addition of two N-bit vectors, N full adders.
module umul_ripple #(
  parameter int N = 7
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  output logic [N:0]   sum
);
  for (genvar j = 0; j < N; j++) begin : g_bit
    logic cin_w;
    logic co_w;
    if (j == 0) begin : g_lsb
      assign cin_w = 1'b0;
    end else begin : g_chain
      assign cin_w = g_bit[j-1].co_w;
    end
    umul_fa u_fa (
      .x (x[j]),
      .y (y[j]),
      .z (cin_w),
      .s (sum[j]),
      .co(co_w)
    );
  end
  assign sum[N] = g_bit[N-1].co_w;
endmodule

// File: rtl/umul_braun_array.sv
// Carry-save reduction of the partial-product grid, (W-1)*(W-1) full adders.
// Row i, column j carries weight 2^(i+j) on its sum and 2^(i+j+1) on its carry.
// W must be at least 2.
module umul_braun_array #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] lo,   // finished product bits [W-1:0]
  output logic [W-2:0] sv,   // leftover sums, weights W..2W-2
  output logic [W-2:0] cv    // leftover carries, weights W..2W-2
);
  logic [W-1:0][W-1:0] pp;

  umul_ppgen #(.W(W)) u_ppgen (
    .a (a),
    .b (b),
    .pp(pp)
  );

  for (genvar i = 0; i < W; i++) begin : g_row
    logic [W-1:0] s;
    logic [W-2:0] c;
    if (i == 0) begin : g_first
      // Top row is the first partial product with no carries yet.
      assign s = pp[0];
      assign c = '0;
    end else begin : g_next
      for (genvar j = 0; j < W - 1; j++) begin : g_col
        umul_fa u_fa (
          .x (pp[i][j]),
          .y (g_row[i-1].s[j+1]),
          .z (g_row[i-1].c[j]),
          .s (s[j]),
          .co(c[j])
        );
      end
      // Leftmost bit of each row passes straight down.
      assign s[W-1] = pp[i][W-1];
    end
    assign lo[i] = s[0];
  end

  assign sv = g_row[W-1].s[W-1:1];
  assign cv = g_row[W-1].c;
endmodule

// File: rtl/umul_array.sv
// Registered unsigned array multiplier with full or high-half output.
module umul_array
  import umul_pkg::*;
#(
  parameter int W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [W-1:0]    op_a,
  input  logic [W-1:0]    op_b,
  input  logic            hi_only,
  output logic            out_valid,
  output logic [2*W-1:0]  product
);
  localparam int PW = 2 * W;

  // ---------------- input stage ----------------
  logic [W-1:0] a_q;
  logic [W-1:0] b_q;
  logic         vld_q;
  out_mode_e    mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q    <= '0;
      b_q    <= '0;
      vld_q  <= 1'b0;
      mode_q <= OUT_FULL;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        a_q    <= op_a;
        b_q    <= op_b;
        mode_q <= out_mode_e'(hi_only);
      end
    end
  end

  // ---------------- combinational array ----------------
  logic [W-1:0]  lo_bits;
  logic [W-2:0]  sum_vec;
  logic [W-2:0]  car_vec;
  logic [W-1:0]  hi_bits;
  logic [PW-1:0] full;

  umul_braun_array #(.W(W)) u_array (
    .a (a_q),
    .b (b_q),
    .lo(lo_bits),
    .sv(sum_vec),
    .cv(car_vec)
  );

  umul_ripple #(.N(W - 1)) u_merge (
    .x  (sum_vec),
    .y  (car_vec),
    .sum(hi_bits)
  );

  assign full = {hi_bits, lo_bits};

  // ---------------- output stage ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      product   <= '0;
    end else begin
      out_valid <= vld_q;
      if (vld_q) begin
        product <= (mode_q == OUT_HIGH) ? {{W{1'b0}}, full[PW-1:W]} : full;
      end
    end
  end

  // ---------------- assertions ----------------
  logic [PW-1:0] ref_full;
  assign ref_full = {{W{1'b0}}, a_q} * {{W{1'b0}}, b_q};

  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && product == '0));

  p_array_exact_r2: assert property (@(posedge clk) disable iff (rst)
    full == ref_full);

  p_full_mode_r2: assert property (@(posedge clk) disable iff (rst)
    (vld_q && mode_q == OUT_FULL) |=> product == $past(ref_full));

  p_high_mode_r3: assert property (@(posedge clk) disable iff (rst)
    (vld_q && mode_q == OUT_HIGH) |=> product == {{W{1'b0}}, $past(ref_full[PW-1:W])});

  p_latency_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !vld_q |=> $stable(product));

  p_max_operands_r7: assert property (@(posedge clk) disable iff (rst)
    (a_q == '1 && b_q == '1) |->
      full == {{(W-1){1'b1}}, 1'b0, {(W-1){1'b0}}, 1'b1});

endmodule

// File: tb/umul_array_bench.sv
`timescale 1ns/1ps
module umul_array_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  // W=4 instance (exhaustive) and W=8 instance (random + corners)
  logic       v4 = 1'b0, m4 = 1'b0;
  logic [3:0] a4 = '0, b4 = '0;
  logic       ov4;
  logic [7:0] p4;

  logic       v8 = 1'b0, m8 = 1'b0;
  logic [7:0] a8 = '0, b8 = '0;
  logic       ov8;
  logic [15:0] p8;

  umul_array #(.W(4)) u_umul_array (
    .clk(clk), .rst(rst), .in_valid(v4), .op_a(a4), .op_b(b4),
    .hi_only(m4), .out_valid(ov4), .product(p4)
  );

  umul_array #(.W(8)) u_umul_array_w8 (
    .clk(clk), .rst(rst), .in_valid(v8), .op_a(a8), .op_b(b8),
    .hi_only(m8), .out_valid(ov8), .product(p8)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // Expected-result queues, two slots deep (input stage + output stage).
  logic       q4_v [0:1];
  logic [7:0] q4_r [0:1];
  string      q4_t [0:1];
  logic       q8_v [0:1];
  logic [15:0] q8_r [0:1];
  string      q8_t [0:1];
  logic [7:0]  last4 = '0;
  logic [15:0] last8 = '0;

  function automatic logic [7:0] ref4(input logic [3:0] a, input logic [3:0] b, input logic m);
    logic [7:0] f;
    f = {4'd0, a} * {4'd0, b};
    return m ? {4'd0, f[7:4]} : f;
  endfunction

  function automatic logic [15:0] ref8(input logic [7:0] a, input logic [7:0] b, input logic m);
    logic [15:0] f;
    f = {8'd0, a} * {8'd0, b};
    return m ? {8'd0, f[15:8]} : f;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got %h exp %h at %0t", tag, got, exp, $time);
    end
  endtask

  // One cycle: check results due now, then apply new stimulus.
  task automatic step(input logic nv4, input logic [3:0] na4, input logic [3:0] nb4, input logic nm4,
                      input logic nv8, input logic [7:0] na8, input logic [7:0] nb8, input logic nm8,
                      input string tag);
    @(negedge clk);
    if (q4_v[1]) last4 = q4_r[1];
    if (q8_v[1]) last8 = q8_r[1];
    chk(ov4 === q4_v[1], "R4 valid w4", {15'd0, ov4}, {15'd0, q4_v[1]});
    chk(p4 === last4, q4_t[1], {8'd0, p4}, {8'd0, last4});
    chk(ov8 === q8_v[1], "R4 valid w8", {15'd0, ov8}, {15'd0, q8_v[1]});
    chk(p8 === last8, q8_t[1], p8, last8);
    q4_v[1] = q4_v[0]; q4_r[1] = q4_r[0]; q4_t[1] = q4_t[0];
    q8_v[1] = q8_v[0]; q8_r[1] = q8_r[0]; q8_t[1] = q8_t[0];
    q4_v[0] = nv4; q4_r[0] = ref4(na4, nb4, nm4); q4_t[0] = {tag, " w4"};
    q8_v[0] = nv8; q8_r[0] = ref8(na8, nb8, nm8); q8_t[0] = {tag, " w8"};
    v4 = nv4; a4 = na4; b4 = nb4; m4 = nm4;
    v8 = nv8; a8 = na8; b8 = nb8; m8 = nm8;
  endtask

  initial begin
    for (int k = 0; k < 2; k++) begin
      q4_v[k] = 1'b0; q4_r[k] = '0; q4_t[k] = "R6 idle";
      q8_v[k] = 1'b0; q8_r[k] = '0; q8_t[k] = "R6 idle";
    end
    // R1: reset dominates even with valid operands offered
    v4 = 1'b1; a4 = 4'hF; b4 = 4'hF;
    v8 = 1'b1; a8 = 8'hFF; b8 = 8'hFF;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(ov4 == 1'b0 && p4 == '0, "R1 reset w4", {7'd0, ov4, p4}, 16'd0);
      chk(ov8 == 1'b0 && p8 == '0, "R1 reset w8", {15'd0, ov8} | p8, 16'd0);
    end
    @(negedge clk);
    rst = 1'b0; v4 = 1'b0; v8 = 1'b0;

    // R7: corner operands in both modes
    step(1, 4'hF, 4'hF, 0, 1, 8'hFF, 8'hFF, 0, "R7 max*max full");
    step(1, 4'hF, 4'hF, 1, 1, 8'hFF, 8'hFF, 1, "R7 max*max high");
    step(1, 4'h0, 4'hF, 0, 1, 8'h00, 8'hFF, 0, "R7 zero");
    step(1, 4'hF, 4'h1, 0, 1, 8'hFF, 8'h01, 0, "R7 max*1");
    step(1, 4'h1, 4'hF, 1, 1, 8'h01, 8'hFF, 1, "R7 1*max high");

    // R6: idle cycles with changing operands and mode
    for (int k = 0; k < 5; k++)
      step(0, 4'(k + 3), 4'(k * 5), k[0], 0, 8'(k * 37), 8'(k * 11 + 1), k[0], "R6 hold");

    // R2/R3/R5: exhaustive W=4, back to back, random W=8 alongside
    for (int m = 0; m < 2; m++)
      for (int ia = 0; ia < 16; ia++)
        for (int ib = 0; ib < 16; ib++)
          step(1, 4'(ia), 4'(ib), m[0], 1, 8'($urandom), 8'($urandom), m[0],
               m == 0 ? "R2 full sweep" : "R3 high sweep");

    // R5: mode alternating per pair, with occasional gaps (R6)
    for (int k = 0; k < 1500; k++) begin
      logic g;
      g = ($urandom % 5) != 0;
      step(g, 4'($urandom), 4'($urandom), k[0], g, 8'($urandom), 8'($urandom), ~k[0],
           g ? "R5 mixed modes" : "R6 gap");
    end

    // drain the pipeline
    for (int k = 0; k < 3; k++)
      step(0, 4'd0, 4'd0, 0, 0, 8'd0, 8'd0, 0, "R6 drain");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired got %0d exp %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule